// File: doc/BRIEF.md
# Indirect-Access Coefficient RAM Controller

This block gives a host processor a path into three internal RAMs, a gain profile RAM, an in-phase (I) coefficient RAM and a quadrature (Q) coefficient RAM, through a small host register window. The host places one or two data words in a data register. It then writes an indirect address word that carries the RAM word address, a two-bit page selector and a direction bit. That single address write fires the RAM transfer. A write commits the queued data into the selected RAM or RAMs. A read puts the addressed word on the host read bus, and the word stays there until the next read.

Two hold bits in a main control register decide who owns the RAMs. While a hold bit is set, the host may access the RAMs behind it and the channel read ports of those RAMs return zero. While a hold bit is clear, the channel reads the RAMs with one cycle of latency and host transfers aimed at them are refused. Each transfer is followed by a fixed busy window. Host writes to the data or address register inside that window are discarded and raise a sticky error flag.

Top module: `coef_ram_ctrl`

## Requirements
- R1: After reset, busy, err, gain_hold, coef_hold, host_rdata and all three channel data outputs are zero.
- R2: A write to offset 0x14 pushes the data register. The older value moves to a second slot. A write strobe with page bits 9:8 = 01 stores the newest value in the I RAM and the previous value in the Q RAM, so the host loads Q first and then I.
- R3: A write strobe with page 11 stores the newest data value in both the I and the Q RAM at the same word address.
- R4: A write strobe with page 00 stores the newest data value in the gain RAM. A write strobe with page 10 stores it in the Q RAM only.
- R5: A write to offset 0x15 is a strobe. Bit 15 = 1 selects a read and bits 7:0 give the word address. After the clock edge that takes the strobe, host_rdata shows the word: page 00 reads gain, pages 01 and 11 read I, and page 10 reads Q. host_rdata stays unchanged until the next accepted read.
- R6: Every write to offset 0x15 taken while not busy raises busy for exactly 4 cycles. A write to 0x14 or 0x15 while busy changes nothing and sets err.
- R7: A strobe whose target RAM has its hold bit clear is dropped. The hold bit is bit 14 for page 00 and bit 12 for all other pages. A dropped strobe leaves every RAM and host_rdata unchanged and sets err.
- R8: err is sticky and is cleared only by a host write to offset 0x16.
- R9: Each channel data output shows the RAM word at the channel address one cycle after that address is applied. It shows zero when the RAM's hold bit was set at that edge. Gain uses bit 14, and I and Q use bit 12.
- R10: A write to offset 0x0c loads the main control register. Bit 14 appears on gain_hold and bit 12 appears on coef_hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Last word read from a RAM by the host |
| busy | output | 1 | Transfer window in progress |
| err | output | 1 | Sticky access error |
| gain_hold | output | 1 | Host owns gain RAM (control bit 14) |
| coef_hold | output | 1 | Host owns coefficient RAMs (control bit 12) |
| ch_gain_addr | input | 8 | Channel gain RAM address |
| ch_coef_addr | input | 8 | Channel coefficient address (I and Q) |
| ch_gain_data | output | 16 | Channel gain word |
| ch_i_data | output | 16 | Channel I coefficient word |
| ch_q_data | output | 16 | Channel Q coefficient word |

## Verification
The bench targets the pairing order in page 01: a design that swapped the two queue slots would store the Q value in I and read back crossed values. It also drives writes into every cycle of the busy window, including the fourth cycle and the cycle just after it. An off-by-one counter would then either accept a write too early or reject a legal one, and err and the stored data would diverge from the model. Strobes are aimed at RAMs whose hold bit is clear, for both reads and writes. A controller that checked the wrong hold bit, or that let a refused read disturb host_rdata, is caught by the next read-back. Channel reads run every cycle and are compared against the word stored before that edge and against the hold bit at that edge.

// File: rtl/cram_pkg.sv
package cram_pkg;
   typedef enum logic [1:0] {
      PG_GAIN = 2'b00,
      PG_I    = 2'b01,
      PG_Q    = 2'b10,
      PG_IQ   = 2'b11
   } page_e;

   localparam int unsigned NBANK   = 3;
   localparam int unsigned BK_GAIN = 0;
   localparam int unsigned BK_I    = 1;
   localparam int unsigned BK_Q    = 2;

   localparam logic [7:0] OFS_CTRL = 8'h0c;
   localparam logic [7:0] OFS_DATA = 8'h14;
   localparam logic [7:0] OFS_IND  = 8'h15;
   localparam logic [7:0] OFS_STAT = 8'h16;

   localparam int unsigned DIR_BIT       = 15;
   localparam int unsigned PAGE_LSB      = 8;
   localparam int unsigned GAIN_HOLD_BIT = 14;
   localparam int unsigned COEF_HOLD_BIT = 12;
endpackage

// File: rtl/cram_host_regs.sv
module cram_host_regs
   import cram_pkg::*;
#(
   parameter int unsigned DW       = 16,
   parameter int unsigned AW       = 8,
   parameter int unsigned HW       = 16,
   parameter int unsigned BUSY_CYC = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_wr,
   input  logic [7:0]                 host_addr,
   input  logic [HW-1:0]              host_wdata,
   output logic                       gain_hold,
   output logic                       coef_hold,
   output logic                       busy,
   output logic                       err,
   output logic [NBANK-1:0]           bank_we,
   output logic [NBANK-1:0]           bank_re,
   output logic [AW-1:0]              bank_addr,
   output logic [NBANK-1:0][DW-1:0]   bank_wdata
);
   localparam int unsigned CW = $clog2(BUSY_CYC + 1);

   logic [DW-1:0] dat_cur, dat_prev;
   logic [CW-1:0] cnt;
   logic          wr_ctrl, wr_data, wr_ind, wr_stat;
   logic          go, dir_rd, hold_ok, granted, err_set;
   page_e         page;

   assign wr_ctrl = host_wr && (host_addr == OFS_CTRL);
   assign wr_data = host_wr && (host_addr == OFS_DATA);
   assign wr_ind  = host_wr && (host_addr == OFS_IND);
   assign wr_stat = host_wr && (host_addr == OFS_STAT);

   assign busy    = (cnt != '0);
   assign go      = wr_ind && !busy;
   assign dir_rd  = host_wdata[DIR_BIT];
   assign page    = page_e'(host_wdata[PAGE_LSB +: 2]);
   assign hold_ok = (page == PG_GAIN) ? gain_hold : coef_hold;
   assign granted = go && hold_ok;
   assign err_set = ((wr_data || wr_ind) && busy) || (go && !hold_ok);
   assign bank_addr = host_wdata[AW-1:0];

   // Strobe decode: page selects the bank set, direction picks we or re
   always_comb begin
      bank_we = '0;
      bank_re = '0;
      if (granted && !dir_rd) begin
         unique case (page)
            PG_GAIN: bank_we[BK_GAIN] = 1'b1;
            PG_I:    begin bank_we[BK_I] = 1'b1; bank_we[BK_Q] = 1'b1; end
            PG_Q:    bank_we[BK_Q] = 1'b1;
            PG_IQ:   begin bank_we[BK_I] = 1'b1; bank_we[BK_Q] = 1'b1; end
            default: bank_we = '0;
         endcase
      end else if (granted) begin
         unique case (page)
            PG_GAIN: bank_re[BK_GAIN] = 1'b1;
            PG_Q:    bank_re[BK_Q] = 1'b1;
            PG_I, PG_IQ: bank_re[BK_I] = 1'b1;
            default: bank_re = '0;
         endcase
      end
   end

   // Paired page takes Q from the older queue slot
   always_comb begin
      bank_wdata[BK_GAIN] = dat_cur;
      bank_wdata[BK_I]    = dat_cur;
      bank_wdata[BK_Q]    = (page == PG_I) ? dat_prev : dat_cur;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gain_hold <= 1'b0;
         coef_hold <= 1'b0;
         dat_cur   <= '0;
         dat_prev  <= '0;
         cnt       <= '0;
         err       <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            gain_hold <= host_wdata[GAIN_HOLD_BIT];
            coef_hold <= host_wdata[COEF_HOLD_BIT];
         end
         if (wr_data && !busy) begin
            dat_prev <= dat_cur;
            dat_cur  <= host_wdata[DW-1:0];
         end
         if (go)
            cnt <= CW'(BUSY_CYC);
         else if (busy)
            cnt <= cnt - 1'b1;
         if (err_set)
            err <= 1'b1;
         else if (wr_stat)
            err <= 1'b0;
      end
   end

   logic unused_bits;
   assign unused_bits = ^host_wdata;

   assert_busy_after_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ind && !busy) |=> busy);
   assert_data_frozen_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data && busy) |=> ($stable(dat_cur) && $stable(dat_prev)));
   assert_err_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> $past(host_wr));
   assert_err_clear_only_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err) |-> $past(wr_stat));
endmodule

// File: rtl/cram_bank.sv
module cram_bank #(
   parameter int unsigned DW = 16,
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          we,
   input  logic          re,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rd_q,
   input  logic [AW-1:0] ch_addr,
   output logic [DW-1:0] ch_data
);
   localparam int unsigned DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[addr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q    <= '0;
         ch_data <= '0;
      end else begin
         if (re)
            rd_q <= mem[addr];
         ch_data <= hold ? '0 : mem[ch_addr];
      end
   end

   assert_write_needs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (we || re) |-> hold);
   assert_channel_blank_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_data != '0) |-> !$past(hold));
   assert_rd_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !re |=> $stable(rd_q));
endmodule

// File: rtl/coef_ram_ctrl.sv
module coef_ram_ctrl
   import cram_pkg::*;
#(
   parameter int unsigned DW       = 16,
   parameter int unsigned AW       = 8,
   parameter int unsigned HW       = 16,
   parameter int unsigned BUSY_CYC = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_wr,
   input  logic [7:0]    host_addr,
   input  logic [HW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          busy,
   output logic          err,
   output logic          gain_hold,
   output logic          coef_hold,
   input  logic [AW-1:0] ch_gain_addr,
   input  logic [AW-1:0] ch_coef_addr,
   output logic [DW-1:0] ch_gain_data,
   output logic [DW-1:0] ch_i_data,
   output logic [DW-1:0] ch_q_data
);
   generate
      if (HW < 16)      begin : g_bad_hw  $error("HW must hold a 16-bit address word"); end
      if (AW > 8)       begin : g_bad_aw  $error("AW must stay below the page field"); end
      if (DW > HW)      begin : g_bad_dw  $error("DW must fit the host bus"); end
      if (BUSY_CYC < 1) begin : g_bad_bc  $error("BUSY_CYC must be at least 1"); end
   endgenerate

   logic [NBANK-1:0]         bank_we, bank_re;
   logic [AW-1:0]            bank_addr;
   logic [NBANK-1:0][DW-1:0] bank_wdata, bank_rd, bank_ch;
   logic [1:0]               rd_sel;

   cram_host_regs #(.DW(DW), .AW(AW), .HW(HW), .BUSY_CYC(BUSY_CYC)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_wr    (host_wr),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .gain_hold  (gain_hold),
      .coef_hold  (coef_hold),
      .busy       (busy),
      .err        (err),
      .bank_we    (bank_we),
      .bank_re    (bank_re),
      .bank_addr  (bank_addr),
      .bank_wdata (bank_wdata)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      localparam bit IS_GAIN = (b == BK_GAIN);
      cram_bank #(.DW(DW), .AW(AW)) bank_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .hold    (IS_GAIN ? gain_hold : coef_hold),
         .we      (bank_we[b]),
         .re      (bank_re[b]),
         .addr    (bank_addr),
         .wdata   (bank_wdata[b]),
         .rd_q    (bank_rd[b]),
         .ch_addr (IS_GAIN ? ch_gain_addr : ch_coef_addr),
         .ch_data (bank_ch[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_sel <= 2'(BK_GAIN);
      else if (bank_re[BK_I])
         rd_sel <= 2'(BK_I);
      else if (bank_re[BK_Q])
         rd_sel <= 2'(BK_Q);
      else if (bank_re[BK_GAIN])
         rd_sel <= 2'(BK_GAIN);
   end

   assign host_rdata   = bank_rd[rd_sel];
   assign ch_gain_data = bank_ch[BK_GAIN];
   assign ch_i_data    = bank_ch[BK_I];
   assign ch_q_data    = bank_ch[BK_Q];

   assert_single_reader_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_re));
   assert_rdata_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(|bank_re) |=> $stable(host_rdata));
   assert_no_strobe_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !(|bank_we) && !(|bank_re));
endmodule

// File: tb/coef_ram_ctrl_tb.sv
module coef_ram_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        host_wr;
   logic [7:0]  host_addr;
   logic [15:0] host_wdata;
   logic [15:0] host_rdata;
   logic        busy, err, gain_hold, coef_hold;
   logic [7:0]  ch_gain_addr, ch_coef_addr;
   logic [15:0] ch_gain_data, ch_i_data, ch_q_data;

   always #5 clk = ~clk;

   coef_ram_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .err(err),
      .gain_hold(gain_hold), .coef_hold(coef_hold),
      .ch_gain_addr(ch_gain_addr), .ch_coef_addr(ch_coef_addr),
      .ch_gain_data(ch_gain_data), .ch_i_data(ch_i_data), .ch_q_data(ch_q_data)
   );

   int total = 0, bad = 0;
   bit finished = 1'b0;
   bit chk_ch = 1'b0;

   logic [15:0] gm [16];
   logic [15:0] im [16];
   logic [15:0] qm [16];
   logic [15:0] m_cur = 0, m_prev = 0, m_rd = 0;
   bit m_err = 0, m_gh = 0, m_ch = 0;
   int m_cnt = 0;

   function automatic logic [15:0] exp_ch(bit hold, logic [15:0] val);
      return hold ? 16'h0 : val;
   endfunction

   function automatic bit hold_for(logic [1:0] pg, bit gh, bit ch);
      return (pg == 2'b00) ? gh : ch;
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // one host cycle; model is updated from its pre-edge state
   task automatic cyc(bit w, logic [7:0] off, logic [15:0] d);
      logic [3:0] cga, cca;
      logic [15:0] eg, ei, eq;
      bit mbusy, go;
      logic [1:0] pg;
      logic [3:0] a;
      cga = 4'($urandom_range(0, 15));
      cca = 4'($urandom_range(0, 15));
      host_wr = w; host_addr = off; host_wdata = d;
      ch_gain_addr = {4'h0, cga}; ch_coef_addr = {4'h0, cca};
      @(posedge clk);
      eg = exp_ch(m_gh, gm[cga]);
      ei = exp_ch(m_ch, im[cca]);
      eq = exp_ch(m_ch, qm[cca]);
      mbusy = (m_cnt != 0);
      go = 1'b0;
      pg = d[9:8];
      a = d[3:0];
      if (w) begin
         if (off == 8'h0c) begin
            m_gh = d[14]; m_ch = d[12];
         end else if (off == 8'h14) begin
            if (mbusy) m_err = 1;
            else begin m_prev = m_cur; m_cur = d; end
         end else if (off == 8'h15) begin
            if (mbusy) m_err = 1;
            else begin
               go = 1'b1;
               if (!hold_for(pg, m_gh, m_ch)) m_err = 1;
               else if (d[15]) begin
                  case (pg)
                     2'b00: m_rd = gm[a];
                     2'b10: m_rd = qm[a];
                     default: m_rd = im[a];
                  endcase
               end else begin
                  case (pg)
                     2'b00: gm[a] = m_cur;
                     2'b01: begin im[a] = m_cur; qm[a] = m_prev; end
                     2'b10: qm[a] = m_cur;
                     default: begin im[a] = m_cur; qm[a] = m_cur; end
                  endcase
               end
            end
         end else if (off == 8'h16) begin
            m_err = 0;
         end
      end
      if (go) m_cnt = 4;
      else if (m_cnt > 0) m_cnt--;
      @(negedge clk);
      host_wr = 1'b0;
      check("R6 busy", {15'h0, busy}, {15'h0, m_cnt != 0});
      check("R8 err", {15'h0, err}, {15'h0, m_err});
      check("R5 host_rdata", host_rdata, m_rd);
      check("R10 holds", {14'h0, gain_hold, coef_hold}, {14'h0, m_gh, m_ch});
      if (chk_ch) begin
         check("R9 ch gain", ch_gain_data, eg);
         check("R9 ch I", ch_i_data, ei);
         check("R9 ch Q", ch_q_data, eq);
      end
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 16'h0);
   endtask

   task automatic strobe(logic [15:0] ind);
      cyc(1'b1, 8'h15, ind);
      idle(4);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 16; i++) begin gm[i] = 0; im[i] = 0; qm[i] = 0; end
      rst_n = 1'b0; host_wr = 0; host_addr = 0; host_wdata = 0;
      ch_gain_addr = 0; ch_coef_addr = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 busy/err/holds", {12'h0, busy, err, gain_hold, coef_hold}, 16'h0);
      check("R1 host_rdata", host_rdata, 16'h0);
      check("R1 channel", ch_gain_data | ch_i_data | ch_q_data, 16'h0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc(1'b1, 8'h0c, 16'h5000);
      // fill used words so every location is defined
      for (int a = 0; a < 16; a++) begin
         cyc(1'b1, 8'h14, 16'(a * 3));
         strobe(16'h0300 | 16'(a));
         cyc(1'b1, 8'h14, 16'(a) ^ 16'h0055);
         strobe(16'h0000 | 16'(a));
      end
      chk_ch = 1'b1;
      // R2 paired write, Q first then I
      cyc(1'b1, 8'h14, 16'h1234);
      cyc(1'b1, 8'h14, 16'hABCD);
      strobe(16'h0105);
      strobe(16'h8105);
      check("R2 I word", host_rdata, 16'hABCD);
      strobe(16'h8205);
      check("R2 Q word", host_rdata, 16'h1234);
      // R3 shared coefficient
      cyc(1'b1, 8'h14, 16'h7777);
      strobe(16'h0306);
      strobe(16'h8206);
      check("R3 Q word", host_rdata, 16'h7777);
      strobe(16'h8306);
      check("R3 I word via page 11", host_rdata, 16'h7777);
      // R4 gain and Q-only writes
      cyc(1'b1, 8'h14, 16'h0F0F);
      strobe(16'h0007);
      cyc(1'b1, 8'h14, 16'hB00B);
      strobe(16'h0207);
      strobe(16'h8007);
      check("R4 gain word", host_rdata, 16'h0F0F);
      strobe(16'h8207);
      check("R4 Q-only word", host_rdata, 16'hB00B);
      strobe(16'h8107);
      check("R4 I untouched", host_rdata, 16'h0015);
      // R6 write during the last busy cycle, then just after
      cyc(1'b1, 8'h14, 16'h2222);
      cyc(1'b1, 8'h15, 16'h0208);
      idle(3);
      cyc(1'b1, 8'h14, 16'hDEAD);
      check("R6 err on busy write", {15'h0, err}, 16'h1);
      cyc(1'b1, 8'h14, 16'h3333);
      cyc(1'b1, 8'h16, 16'h0);
      check("R8 err cleared", {15'h0, err}, 16'h0);
      strobe(16'h0208);
      strobe(16'h8208);
      check("R6 ignored data absent", host_rdata, 16'h3333);
      // R7 drop when hold is clear
      cyc(1'b1, 8'h0c, 16'h1000);
      cyc(1'b1, 8'h14, 16'h9999);
      strobe(16'h0002);
      check("R7 err on dropped write", {15'h0, err}, 16'h1);
      strobe(16'h8002);
      check("R7 dropped read keeps rdata", host_rdata, 16'h3333);
      cyc(1'b1, 8'h0c, 16'h4000);
      strobe(16'h8002);
      check("R7 gain unchanged", host_rdata, 16'h0057);
      strobe(16'h0103);
      cyc(1'b1, 8'h16, 16'h0);
      // R9 channel reads with holds released
      cyc(1'b1, 8'h0c, 16'h0000);
      idle(40);
      // random mix
      for (int n = 0; n < 4000; n++) begin
         int r;
         logic [15:0] v;
         r = int'($urandom_range(0, 99));
         if (r < 30) cyc(1'b1, 8'h14, 16'($urandom));
         else if (r < 55) begin
            v = {1'($urandom_range(0, 1)), 5'h0, 2'($urandom_range(0, 3)),
                 4'h0, 4'($urandom_range(0, 15))};
            cyc(1'b1, 8'h15, v);
         end else if (r < 61) begin
            v = 16'h0;
            v[14] = ($urandom_range(0, 99) < 85);
            v[12] = ($urandom_range(0, 99) < 85);
            cyc(1'b1, 8'h0c, v);
         end else if (r < 64) cyc(1'b1, 8'h16, 16'h0);
         else idle(1);
      end
      finish_up();
   end
endmodule